// File: doc/BRIEF.md
# Configurable Logic Cell with Arithmetic Mode

This block is a single programmable logic cell of the kind tiled across a reconfigurable fabric. Two small lookup tables, each eight bits of configuration, are addressed by the same three low logic inputs. In normal mode a multiplexer steered by the fourth input picks one of the two table outputs, so the pair acts as one four-input function. In arithmetic mode the two table outputs become the operands of a one-bit full adder whose third input is a carry arriving from a neighbouring cell. The adder's carry leaves the cell so that cells can be chained into ripple adders.

Configuration inputs choose the mode, whether the cell output takes the adder sum or the table path, and whether that output is passed straight through or captured in a D flip-flop on the rising clock edge. The configuration is held outside the cell and presented as static levels. A synchronous active-high reset clears only the flip-flop.

Top module: `cfg_logic_cell`

## Requirements
- R1: Each table output is the bit of its 8-bit configuration word at index {dIn[2],dIn[1],dIn[0]}, with dIn[0] as the least significant address bit; lutCfgLo feeds the low table and lutCfgHi the high table.
- R2: With cfgSumSel=0 the unregistered cell value is the high table output when dIn[3]=1 and the low table output when dIn[3]=0, in either mode.
- R3: With cfgSumSel=1 the unregistered cell value is the full-adder sum, low XOR high XOR carryIn.
- R4: With cfgArith=1, carryOut is the full-adder carry: 1 when at least two of low table output, high table output and carryIn are 1.
- R5: With cfgArith=0, carryOut is 0 whatever the other inputs are.
- R6: With cfgRegOut=0, cellOut follows the unregistered cell value in the same cycle, with no clock edge needed.
- R7: With cfgRegOut=1, cellOut changes only on a rising clock edge and shows the unregistered cell value present just before that edge.
- R8: With rst=1 at a rising edge the flip-flop becomes 0, so a registered cellOut reads 0 after that edge; the reset has no effect between edges and does not alter the unregistered path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output flip-flop |
| lutCfgLo | input | 8 | Truth table of the low lookup table |
| lutCfgHi | input | 8 | Truth table of the high lookup table |
| cfgArith | input | 1 | 1 selects arithmetic mode, 0 normal mode |
| cfgSumSel | input | 1 | 1 takes the adder sum, 0 the table path |
| cfgRegOut | input | 1 | 1 takes the flip-flop output, 0 the direct value |
| dIn | input | 4 | Logic inputs; bits 2..0 address the tables, bit 3 steers the table merge |
| carryIn | input | 1 | Carry from the neighbouring cell |
| cellOut | output | 1 | Cell logic output |
| carryOut | output | 1 | Carry to the next cell |

## Verification
Every one of the sixteen input combinations is applied in normal mode with two tables holding different patterns, which shows the address bit order and that dIn[3] picks the right table rather than a mirrored one. Arithmetic mode is driven with tables set to pass dIn[0] and dIn[1] through, so all eight adder input combinations show up directly on the sum and carry and separate a correct majority from an OR or an XOR. Random configurations, modes and inputs, checked in both registered and direct output settings, catch mismatches in the selection muxes and one-cycle timing, while a reset pulse with a 1 held in the flip-flop shows that the clear waits for the clock edge and leaves the direct path alone.

// File: rtl/cell_pkg.sv
package cell_pkg;
  // Number of address bits of each lookup table.
  parameter int LUT_IN = 3;
  localparam int LUT_BITS = 1 << LUT_IN;
  localparam int NUM_LUTS = 2;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic arithEn;  // adder carry drives carryOut
    logic takeSum;  // output source is the adder sum
    logic takeReg;  // output comes from the flip-flop
  } cell_strobe_t;
endpackage

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import cell_pkg::*;
(
  input  logic         cfgArith,
  input  logic         cfgSumSel,
  input  logic         cfgRegOut,
  output cell_strobe_t strobe
);
  always_comb begin
    strobe         = '0;
    strobe.arithEn = cfgArith;
    strobe.takeSum = cfgSumSel;
    strobe.takeReg = cfgRegOut;
  end
endmodule

// File: rtl/cell_datapath.sv
module cell_datapath
  import cell_pkg::*;
#(
  parameter int LIN = cell_pkg::LUT_IN,
  localparam int LBITS = 1 << LIN
) (
  input  logic             clk,
  input  logic             rst,
  input  cell_strobe_t     strobe,
  input  logic [LBITS-1:0] lutCfgLo,
  input  logic [LBITS-1:0] lutCfgHi,
  input  logic [LIN:0]     dIn,
  input  logic             carryIn,
  output logic             lutLo,
  output logic             lutHi,
  output logic             combOut,
  output logic             cellOut,
  output logic             carryOut
);
  logic [NUM_LUTS-1:0][LBITS-1:0] lutCfg;
  logic [NUM_LUTS-1:0]            lutVal;
  logic [LIN-1:0]                 lutAddr;
  logic                           mergedLut;
  logic                           adderSum;
  logic                           adderCarry;
  logic                           flopQ;

  assign lutCfg[0] = lutCfgLo;
  assign lutCfg[1] = lutCfgHi;
  assign lutAddr   = dIn[LIN-1:0];

  // One table lookup per LUT.
  for (genvar g = 0; g < NUM_LUTS; g++) begin : g_lut
    assign lutVal[g] = lutCfg[g][lutAddr];
  end

  assign lutLo = lutVal[0];
  assign lutHi = lutVal[1];

  // Merge the two tables into one wider function using the top input.
  assign mergedLut = dIn[LIN] ? lutVal[1] : lutVal[0];

  // One-bit full adder on the table outputs and the incoming carry.
  assign adderSum   = lutVal[0] ^ lutVal[1] ^ carryIn;
  assign adderCarry = (lutVal[0] & lutVal[1]) | (carryIn & (lutVal[0] ^ lutVal[1]));

  assign combOut  = strobe.takeSum ? adderSum : mergedLut;
  assign carryOut = strobe.arithEn & adderCarry;

  always_ff @(posedge clk) begin
    if (rst) flopQ <= 1'b0;
    else     flopQ <= combOut;
  end

  assign cellOut = strobe.takeReg ? flopQ : combOut;
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LUT_BITS-1:0] lutCfgLo,
  input  logic [LUT_BITS-1:0] lutCfgHi,
  input  logic                cfgArith,
  input  logic                cfgSumSel,
  input  logic                cfgRegOut,
  input  logic [LUT_IN:0]     dIn,
  input  logic                carryIn,
  output logic                cellOut,
  output logic                carryOut
);
  cell_strobe_t strobe;
  logic         lutLo;
  logic         lutHi;
  logic         combOut;

  cell_ctrl u_ctrl (
    .cfgArith (cfgArith),
    .cfgSumSel(cfgSumSel),
    .cfgRegOut(cfgRegOut),
    .strobe   (strobe)
  );

  cell_datapath #(.LIN(LUT_IN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .lutCfgLo(lutCfgLo),
    .lutCfgHi(lutCfgHi),
    .dIn     (dIn),
    .carryIn (carryIn),
    .lutLo   (lutLo),
    .lutHi   (lutHi),
    .combOut (combOut),
    .cellOut (cellOut),
    .carryOut(carryOut)
  );
endmodule

// File: rtl/cell_checker.sv
module cell_checker (
  input logic clk,
  input logic rst,
  input logic cfgArith,
  input logic cfgRegOut,
  input logic carryIn,
  input logic lutLo,
  input logic lutHi,
  input logic combOut,
  input logic cellOut,
  input logic carryOut
);
  // R5: carry leaves as 0 in normal mode
  a_r5_carry_idle: assert property (@(posedge clk) disable iff (rst)
    !cfgArith |-> carryOut == 1'b0);

  // R4: carry is the majority of the adder inputs in arithmetic mode
  a_r4_carry_major: assert property (@(posedge clk) disable iff (rst)
    cfgArith |-> carryOut == ((lutLo & lutHi) | (lutLo & carryIn) | (lutHi & carryIn)));

  // R6: direct output tracks the cell value
  a_r6_direct: assert property (@(posedge clk) disable iff (rst)
    !cfgRegOut |-> cellOut == combOut);

  // R7: registered output shows the previous cycle's cell value
  a_r7_registered: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!cfgRegOut || cellOut == $past(combOut)));

  // R8: reset at an edge clears the registered output
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!cfgRegOut || cellOut == 1'b0));
endmodule

bind cfg_logic_cell cell_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfgArith (cfgArith),
  .cfgRegOut(cfgRegOut),
  .carryIn  (carryIn),
  .lutLo    (lutLo),
  .lutHi    (lutHi),
  .combOut  (combOut),
  .cellOut  (cellOut),
  .carryOut (carryOut)
);

// File: tb/sim_cfg_logic_cell.sv
`timescale 1ns/1ps
module sim_cfg_logic_cell;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] lutCfgLo, lutCfgHi;
  logic       cfgArith, cfgSumSel, cfgRegOut;
  logic [3:0] dIn;
  logic       carryIn;
  logic       cellOut, carryOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;
  logic modelQ;

  always #5 clk = ~clk;

  cfg_logic_cell u0 (
    .clk(clk), .rst(rst), .lutCfgLo(lutCfgLo), .lutCfgHi(lutCfgHi),
    .cfgArith(cfgArith), .cfgSumSel(cfgSumSel), .cfgRegOut(cfgRegOut),
    .dIn(dIn), .carryIn(carryIn), .cellOut(cellOut), .carryOut(carryOut)
  );

  function automatic logic fLut(input logic [7:0] cfg, input logic [3:0] d);
    return cfg[d[2:0]];
  endfunction

  function automatic logic fComb();
    logic a, b;
    a = fLut(lutCfgLo, dIn);
    b = fLut(lutCfgHi, dIn);
    if (cfgSumSel) return a ^ b ^ carryIn;
    return dIn[3] ? b : a;
  endfunction

  function automatic logic fCarry();
    logic a, b;
    a = fLut(lutCfgLo, dIn);
    b = fLut(lutCfgHi, dIn);
    if (!cfgArith) return 1'b0;
    return (a & b) | (a & carryIn) | (b & carryIn);
  endfunction

  always @(posedge clk) modelQ <= rst ? 1'b0 : fComb();

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b (cfgLo=%h cfgHi=%h dIn=%h cin=%b)",
               req, act, exp, lutCfgLo, lutCfgHi, dIn, carryIn);
    end
  endtask

  // Checks the output for the current inputs; called 2 ns after a falling edge.
  task automatic chkOut(input string req);
    chk(req, cellOut, cfgRegOut ? modelQ : fComb());
    chk(cfgArith ? "R4 carry" : "R5 carry", carryOut, fCarry());
  endtask

  task automatic drive(input logic [7:0] lo, input logic [7:0] hi, input logic ar,
                       input logic ss, input logic rg, input logic [3:0] d, input logic ci);
    @(negedge clk);
    lutCfgLo = lo; lutCfgHi = hi; cfgArith = ar; cfgSumSel = ss;
    cfgRegOut = rg; dIn = d; carryIn = ci;
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    lutCfgLo = 8'h00; lutCfgHi = 8'h00; cfgArith = 0; cfgSumSel = 0;
    cfgRegOut = 1; dIn = 4'h0; carryIn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R8 reset state", cellOut, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R1 R2: all sixteen inputs in normal mode, direct output
    for (int i = 0; i < 16; i++) begin
      drive(8'b1011_0010, 8'b0110_1101, 1'b0, 1'b0, 1'b0, 4'(i), i[0]);
      chk("R1/R2 normal lookup", cellOut, (i >= 8) ? 8'b0110_1101 >> (i - 8) & 1'b1
                                                  : 8'b1011_0010 >> i & 1'b1);
      chk("R5 carry idle", carryOut, 1'b0);
    end

    // R3 R4: tables pass dIn[0] (low) and dIn[1] (high); all adder inputs
    for (int i = 0; i < 8; i++) begin
      logic a, b, c;
      a = i[0]; b = i[1]; c = i[2];
      drive(8'hAA, 8'hCC, 1'b1, 1'b1, 1'b0, {2'b00, b, a}, c);
      chk("R3 adder sum", cellOut, a ^ b ^ c);
      chk("R4 adder carry", carryOut, (a & b) | (a & c) | (b & c));
    end

    // R7: registered output holds between edges
    drive(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0);
    @(negedge clk); #2;
    chk("R7 registered one", cellOut, 1'b1);
    @(negedge clk); lutCfgLo = 8'h00; lutCfgHi = 8'h00; #2;
    chk("R7 holds until edge", cellOut, 1'b1);
    @(negedge clk); #2;
    chk("R7 updates after edge", cellOut, 1'b0);

    // R8: synchronous reset with a 1 in the flop
    drive(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 4'h3, 1'b0);
    @(negedge clk); rst = 1'b1; #2;
    chk("R8 no effect before edge", cellOut, 1'b1);
    cfgRegOut = 1'b0; #1;
    chk("R8 direct path untouched", cellOut, 1'b1);
    cfgRegOut = 1'b1;
    @(negedge clk); #2;
    chk("R8 cleared after edge", cellOut, 1'b0);
    @(negedge clk); rst = 1'b0;

    // Random mix covering R1..R7
    for (int n = 0; n < 400; n++) begin
      drive(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 4'($urandom), 1'($urandom));
      chkOut(cfgRegOut ? "R7 random registered" : "R6 random direct");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule